// File: doc/BRIEF.md
# Hybrid Two-Stage Decoding Sequencer

This block is the control unit that steps a soft-decision decoding job between two separate decoders. One is an outer iterative parity-check decoder and the other is an inner row/column array decoder. The sequencer starts the outer decoder and counts its iterations. It watches the per-iteration syndrome result and keeps the smallest number of unsatisfied checks seen in the current run.

A satisfied syndrome ends the job at once with success. When a run reaches its iteration limit, the smallest count decides the outcome:

- If the count is at or above a programmable threshold, the failure is not a trap and the job ends failed.
- If the count is below the threshold, the failure is treated as a trapping-set stall. The sequencer then hands the soft values to the inner decoder for a fixed number of iterations. Next it asks the soft-value store to re-seed the outer decoder's inputs, and then restarts the outer decoder.

Re-seed modes alternate, pinning first and flipping next. A limit on the number of inner/outer rounds stops a job that keeps getting trapped.

The decoders, the interleaver and all soft-value arithmetic sit outside this block and are reached through plain start/report pins. Every pin is a control or status level or a single-cycle pulse; no data stream crosses the block's edge, so there is no back-pressure. The neighbours must follow the pulse protocol given in the requirements. Reports that arrive in the wrong phase are ignored.

Top module: `hds_seq`

## Requirements
- R1: After reset, busy, done, success and failed are 0, and tot_iters, rounds and last_mode are 0.
- R2: A start pulse while idle gives out_start in the same cycle, raises busy from the next cycle, and clears success, failed, tot_iters, rounds and last_mode. A start pulse while busy has no effect.
- R3: An outer iteration report with out_syn_ok=1 asserts out_halt in the same cycle. In the following cycle, done is high for exactly one cycle with success=1 and failed=0. success and failed are never both 1.
- R4: An outer run takes at most MAX_OUT (default 40) iteration reports. out_halt is asserted on the MAX_OUT-th report of a run.
- R5: During each outer run the smallest out_unsat value is tracked, including the value on the final report. The run counts as trapped only when that minimum is strictly below trap_thresh.
- R6: A run that reaches MAX_OUT without converging and is not trapped ends the job. done pulses with failed=1 in the next cycle, there is no in_start, and rounds and last_mode are unchanged.
- R7: A trapped run with rounds below MAX_ROUNDS pulses in_start in the cycle of its last report. seed_start is pulsed on the IN_ITERS-th (default 5) in_it_valid report after that.
- R8: Round k (counting from 1) re-seeds with seed_mode 1 (pin) when k is odd and 2 (flip) when k is even. last_mode takes that value from the cycle after seed_start; 0 means no re-seeding.
- R9: seed_done while waiting for the re-seed pulses out_start in the same cycle and begins a new outer run, with its iteration count and minimum reset.
- R10: rounds counts in_start pulses and never exceeds MAX_ROUNDS (default 4). A trapped run when rounds equals MAX_ROUNDS ends the job with failed=1.
- R11: tot_iters counts every outer iteration report accepted during outer runs of the current job.
- R12: out_it_valid outside an outer run, in_it_valid outside an inner run, and seed_done outside the re-seed wait are ignored. At most one of out_start, in_start and seed_start is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse: begin a decoding job |
| trap_thresh | input | CW | Trap threshold on the minimum unsatisfied count |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse at job end |
| success | output | 1 | Last job converged (held until next start) |
| failed | output | 1 | Last job failed (held until next start) |
| out_start | output | 1 | Pulse: start an outer decoder run |
| out_halt | output | 1 | Pulse: outer decoder must stop now |
| out_it_valid | input | 1 | Pulse: outer iteration report |
| out_syn_ok | input | 1 | Syndrome satisfied on this report |
| out_unsat | input | CW | Unsatisfied check count on this report |
| in_start | output | 1 | Pulse: start an inner array decoder run |
| in_it_valid | input | 1 | Pulse: inner iteration finished |
| seed_start | output | 1 | Pulse: re-seed outer decoder soft inputs |
| seed_mode | output | 2 | Re-seed mode with seed_start: 1 pin, 2 flip |
| seed_done | input | 1 | Pulse: re-seed finished |
| tot_iters | output | TW | Outer iterations used in this job |
| rounds | output | RW | Inner rounds started in this job |
| last_mode | output | 2 | Last re-seed mode: 0 none, 1 pin, 2 flip |

## Verification
A corrupted minimum tracker shows up only at the end of a run, on the 40th report. It appears there as an in_start where done with failed was due, or the reverse; the threshold-equal and last-report-minimum cases are aimed at exactly that cycle. A wrong phase or counter shows up within one cycle as a missing or extra start/halt pulse, or later as a wrong tot_iters, rounds or last_mode. The bench's per-clock model compares every pin, so the first diverging cycle is reported.

// File: rtl/hds_pkg.sv
package hds_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OUTER = 2'd1,
    PH_INNER = 2'd2,
    PH_SEED  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    MD_NONE = 2'd0,
    MD_PIN  = 2'd1,
    MD_FLIP = 2'd2
  } mode_t;
endpackage

// File: rtl/hds_counter.sv
module hds_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/hds_min_track.sv
module hds_min_track #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [CW-1:0] sample,
  output logic [CW-1:0] min_nxt
);
  logic [CW-1:0] min_q;

  // running minimum including the sample presented this cycle
  assign min_nxt = (sample < min_q) ? sample : min_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   min_q <= '1;
    else if (clr) min_q <= '1;
    else if (upd) min_q <= min_nxt;
  end

  AST_MIN_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (min_q <= $past(min_q))); // R5
endmodule

// File: rtl/hds_seq.sv
module hds_seq
  import hds_pkg::*;
#(
  parameter int MAX_OUT    = 40,
  parameter int IN_ITERS   = 5,
  parameter int MAX_ROUNDS = 4,
  parameter int CW         = 12,
  localparam int TW  = $clog2(MAX_OUT * (MAX_ROUNDS + 1) + 1),
  localparam int RW  = $clog2(MAX_ROUNDS + 1),
  localparam int OW  = $clog2(MAX_OUT + 1),
  localparam int NW  = $clog2(IN_ITERS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] trap_thresh,
  output logic          busy,
  output logic          done,
  output logic          success,
  output logic          failed,
  output logic          out_start,
  output logic          out_halt,
  input  logic          out_it_valid,
  input  logic          out_syn_ok,
  input  logic [CW-1:0] out_unsat,
  output logic          in_start,
  input  logic          in_it_valid,
  output logic          seed_start,
  output logic [1:0]    seed_mode,
  input  logic          seed_done,
  output logic [TW-1:0] tot_iters,
  output logic [RW-1:0] rounds,
  output logic [1:0]    last_mode
);
  phase_t        ph_q;
  logic          done_q, succ_q, fail_q;
  mode_t         mode_q;
  logic [OW-1:0] run_cnt;
  logic [NW-1:0] inner_cnt;
  logic [CW-1:0] min_nxt;

  logic acc_start, rpt_out, run_last, conv, trap, round_left;
  logic go_inner, finish, rpt_in, reseed_go;

  // phase decode of incoming reports
  assign acc_start  = (ph_q == PH_IDLE) && start;
  assign rpt_out    = (ph_q == PH_OUTER) && out_it_valid;
  assign run_last   = rpt_out && (run_cnt == OW'(MAX_OUT - 1));
  assign conv       = rpt_out && out_syn_ok;
  assign trap       = min_nxt < trap_thresh;
  assign round_left = rounds < RW'(MAX_ROUNDS);
  assign go_inner   = run_last && !out_syn_ok && trap && round_left;
  assign finish     = conv || (run_last && !go_inner);
  assign rpt_in     = (ph_q == PH_INNER) && in_it_valid;
  assign reseed_go  = (ph_q == PH_SEED) && seed_done;

  // handshake pulses
  assign out_start  = acc_start || reseed_go;
  assign out_halt   = conv || run_last;
  assign in_start   = go_inner;
  assign seed_start = rpt_in && (inner_cnt == NW'(IN_ITERS - 1));
  assign seed_mode  = rounds[0] ? MD_PIN : MD_FLIP;

  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;
  assign success   = succ_q;
  assign failed    = fail_q;
  assign last_mode = mode_q;

  hds_counter #(.W(OW)) u_run_cnt (
    .clk(clk), .rst_n(rst_n), .clr(out_start), .inc(rpt_out), .q(run_cnt)
  );

  hds_counter #(.W(NW)) u_inner_cnt (
    .clk(clk), .rst_n(rst_n), .clr(in_start), .inc(rpt_in), .q(inner_cnt)
  );

  hds_counter #(.W(TW)) u_tot_cnt (
    .clk(clk), .rst_n(rst_n), .clr(acc_start), .inc(rpt_out), .q(tot_iters)
  );

  hds_counter #(.W(RW)) u_round_cnt (
    .clk(clk), .rst_n(rst_n), .clr(acc_start), .inc(in_start), .q(rounds)
  );

  hds_min_track #(.CW(CW)) u_min (
    .clk(clk), .rst_n(rst_n), .clr(out_start), .upd(rpt_out),
    .sample(out_unsat), .min_nxt(min_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
      succ_q <= 1'b0;
      fail_q <= 1'b0;
      mode_q <= MD_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start) begin
          ph_q   <= PH_OUTER;
          succ_q <= 1'b0;
          fail_q <= 1'b0;
          mode_q <= MD_NONE;
        end
        PH_OUTER: begin
          if (finish) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
            succ_q <= conv;
            fail_q <= !conv;
          end else if (go_inner) begin
            ph_q <= PH_INNER;
          end
        end
        PH_INNER: if (seed_start) begin
          ph_q   <= PH_SEED;
          mode_q <= mode_t'(seed_mode);
        end
        PH_SEED: if (seed_done) ph_q <= PH_OUTER;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_start, in_start, seed_start})); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(success && failed)); // R3
  AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= OW'(MAX_OUT)); // R4
  AST_ROUNDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rounds <= RW'(MAX_ROUNDS)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
endmodule

// File: tb/tb_hds_seq.sv
module tb_hds_seq;
  localparam int MO = 40;
  localparam int NI = 5;
  localparam int MR = 4;
  localparam int CW = 12;
  localparam int TW = $clog2(MO * (MR + 1) + 1);
  localparam int RW = $clog2(MR + 1);
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] trap_thresh = '0;
  logic busy, done, success, failed, out_start, out_halt, in_start, seed_start;
  logic out_it_valid = 1'b0, out_syn_ok = 1'b0, in_it_valid = 1'b0, seed_done = 1'b0;
  logic [CW-1:0] out_unsat = '0;
  logic [1:0] seed_mode, last_mode;
  logic [TW-1:0] tot_iters;
  logic [RW-1:0] rounds;

  hds_seq #(.MAX_OUT(MO), .IN_ITERS(NI), .MAX_ROUNDS(MR), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .trap_thresh(trap_thresh),
    .busy(busy), .done(done), .success(success), .failed(failed),
    .out_start(out_start), .out_halt(out_halt), .out_it_valid(out_it_valid),
    .out_syn_ok(out_syn_ok), .out_unsat(out_unsat), .in_start(in_start),
    .in_it_valid(in_it_valid), .seed_start(seed_start), .seed_mode(seed_mode),
    .seed_done(seed_done), .tot_iters(tot_iters), .rounds(rounds),
    .last_mode(last_mode)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: phase 0 idle, 1 outer, 2 inner, 3 seed
  int m_ph = 0, m_run = 0, m_min = MAXV, m_inn = 0, m_rounds = 0, m_tot = 0, m_mode = 0;
  bit m_done = 0, m_succ = 0, m_fail = 0;

  function automatic int lo(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_run = 0; m_min = MAXV; m_inn = 0; m_rounds = 0; m_tot = 0;
      m_mode = 0; m_done = 0; m_succ = 0; m_fail = 0;
    end else begin
      int m;
      m_done = 0;
      case (m_ph)
        0: if (start) begin
          m_ph = 1; m_run = 0; m_min = MAXV; m_tot = 0; m_rounds = 0;
          m_mode = 0; m_succ = 0; m_fail = 0;
        end
        1: if (out_it_valid) begin
          m_tot++; m_run++;
          m = lo(m_min, int'(out_unsat));
          if (out_syn_ok) begin
            m_ph = 0; m_done = 1; m_succ = 1; m_fail = 0;
          end else if (m_run == MO) begin
            if (m >= int'(trap_thresh) || m_rounds == MR) begin
              m_ph = 0; m_done = 1; m_succ = 0; m_fail = 1;
            end else begin
              m_ph = 2; m_inn = 0; m_rounds++;
            end
          end else m_min = m;
        end
        2: if (in_it_valid) begin
          m_inn++;
          if (m_inn == NI) begin
            m_ph = 3; m_mode = (m_rounds % 2 == 1) ? 1 : 2;
          end
        end
        default: if (seed_done) begin
          m_ph = 1; m_run = 0; m_min = MAXV;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      bit e_os, e_halt, e_in, e_seed, lastr;
      lastr  = (m_ph == 1) && out_it_valid && (m_run + 1 == MO);
      e_os   = ((m_ph == 0) && start) || ((m_ph == 3) && seed_done);
      e_halt = ((m_ph == 1) && out_it_valid && out_syn_ok) || lastr;
      e_in   = lastr && !out_syn_ok && (lo(m_min, int'(out_unsat)) < int'(trap_thresh))
               && (m_rounds < MR);
      e_seed = (m_ph == 2) && in_it_valid && (m_inn + 1 == NI);
      chk(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
      chk(done == m_done, "R3 done", done, m_done);
      chk(success == m_succ, "R3 success", success, m_succ);
      chk(failed == m_fail, "R6 failed", failed, m_fail);
      chk(int'(tot_iters) == m_tot, "R11 tot_iters", tot_iters, m_tot);
      chk(int'(rounds) == m_rounds, "R10 rounds", rounds, m_rounds);
      chk(int'(last_mode) == m_mode, "R8 last_mode", last_mode, m_mode);
      chk(out_start == e_os, "R9 out_start", out_start, e_os);
      chk(out_halt == e_halt, "R4 out_halt", out_halt, e_halt);
      chk(in_start == e_in, "R7 in_start", in_start, e_in);
      chk(seed_start == e_seed, "R7 seed_start", seed_start, e_seed);
      if (e_seed)
        chk(int'(seed_mode) == (((m_rounds % 2) == 1) ? 1 : 2), "R8 seed_mode",
            seed_mode, ((m_rounds % 2) == 1) ? 1 : 2);
    end
  end

  task automatic drv(input bit st, input bit iv, input bit sy, input int us,
                     input bit inv, input bit sd);
    @(posedge clk); #1;
    start = st; out_it_valid = iv; out_syn_ok = sy; out_unsat = CW'(us);
    in_it_valid = inv; seed_done = sd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_outer(input int n, input int base, input int lastu, input bit conv);
    for (int i = 0; i < n; i++)
      drv(0, 1, conv && (i == n - 1), (i == n - 1) ? lastu : base, 0, 0);
  endtask

  task automatic inner_seed();
    for (int i = 0; i < NI; i++) drv(0, 0, 0, 0, 1, 0);
    drv(0, 0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    trap_thresh = CW'(5);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(success == 0 && failed == 0, "R1 verdict", {success, failed}, 0);
    chk(tot_iters == 0 && rounds == 0 && last_mode == 0, "R1 status", tot_iters, 0);
    rst_n = 1'b1;
    idle(2);

    // converge on third report
    drv(1, 0, 0, 0, 0, 0);
    run_outer(3, 10, 0, 1);
    idle(2);
    @(negedge clk);
    chk(success == 1 && failed == 0, "R3 converge", success, 1);
    chk(int'(tot_iters) == 3, "R11 three iters", tot_iters, 3);

    // not trapped: minimum equals threshold
    drv(1, 0, 0, 0, 0, 0);
    run_outer(MO, 9, 5, 0);
    idle(2);
    @(negedge clk);
    chk(failed == 1, "R5 min equal thresh not trapped", failed, 1);
    chk(rounds == 0 && last_mode == 0, "R6 no reseed", rounds, 0);

    // trapped via last report only, pin re-seed, then converge
    drv(1, 0, 0, 0, 0, 0);
    run_outer(MO, 9, 4, 0);
    inner_seed();
    run_outer(2, 9, 0, 1);
    idle(2);
    @(negedge clk);
    chk(success == 1, "R5 last report min trapped", success, 1);
    chk(int'(last_mode) == 1 && int'(rounds) == 1, "R8 pin first", last_mode, 1);
    chk(int'(tot_iters) == MO + 2, "R11 total across runs", tot_iters, MO + 2);

    // stray reports while idle
    drv(0, 1, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    drv(0, 0, 0, 0, 0, 1);
    idle(2);
    @(negedge clk);
    chk(busy == 0 && int'(tot_iters) == MO + 2, "R12 idle reports ignored", tot_iters, MO + 2);

    // start and inner report during outer run ignored
    drv(1, 0, 0, 0, 0, 0);
    drv(1, 0, 0, 0, 1, 0);
    drv(0, 0, 0, 0, 0, 1);
    run_outer(1, 0, 0, 1);
    idle(2);
    @(negedge clk);
    chk(success == 1 && int'(tot_iters) == 1 && rounds == 0, "R12 busy start ignored", tot_iters, 1);

    // always trapped: round limit
    drv(1, 0, 0, 0, 0, 0);
    for (int r = 0; r < MR; r++) begin
      run_outer(MO, 2, 2, 0);
      drv(0, 1, 0, 0, 0, 0);   // stray outer report in inner phase
      inner_seed();
    end
    run_outer(MO, 2, 2, 0);
    idle(2);
    @(negedge clk);
    chk(failed == 1 && int'(rounds) == MR, "R10 round limit", rounds, MR);
    chk(int'(last_mode) == 2, "R8 flip last", last_mode, 2);
    chk(int'(tot_iters) == MO * (MR + 1), "R11 full count", tot_iters, MO * (MR + 1));

    idle(2);
    summary();
  end
endmodule